// File: doc/BRIEF.md
# Priority-Based Reference Clock Selector

This block chooses which of several candidate reference clocks should drive a downstream digital PLL. Each candidate carries a 4-bit priority, held in a small bank of configuration registers, and a validity flag supplied each cycle by an external clock monitor. The block combines the two into an eligibility mask. It then registers a selected index and a three-entry table of the best eligible candidates.

Two switching policies are supported. In revertive operation, a candidate with a strictly better priority takes over as soon as it is eligible. In nonrevertive operation, the current choice is kept while it stays eligible, and the better candidate only shows up at the top of the table. Candidates that share a priority value are ordered by a fixed circular list over the input indices, so a failover among peers moves to the next peer after the lost one. A parameter ties the block permanently to revertive operation, for a secondary loop that never runs nonrevertive.

Top module: `refclk_priority_selector`

## Requirements
- R1: While reset is asserted, and at release, sel_none is 1, sel_idx is 0, every table slot reports none with index 0, and every stored priority is 0.
- R2: A cycle with cfg_wr high stores cfg_prio as the priority of input cfg_idx at that clock edge. Priority 0 makes an input ineligible. Values 1 to 15 are usable, and 1 is the best. The new value first affects the outputs registered at the following edge.
- R3: Outputs change only at a rising clock edge. They reflect ref_valid, revert_mode and the stored priorities as sampled at that edge.
- R4: When no input is both valid and nonzero in priority, the next registered outputs are sel_none = 1 and sel_idx = 0.
- R5: When nothing is selected and some input becomes eligible, the input with the best priority is selected. Ties go to the lowest index.
- R6: When the selected input becomes ineligible and another is eligible, selection moves to the best eligible priority. Among peers at that priority, the first in circular index order after the old selected index is chosen, and any ineligible peer is skipped.
- R7: With revertive operation active, an eligible input whose priority is strictly better than the selected input's takes over at the next edge. The tie among such inputs is broken in circular order after the current index.
- R8: With revertive operation inactive, an eligible selection is never replaced.
- R9: An eligible selection is never replaced by an input of equal priority, even under revertive operation.
- R10: Table slot 0 holds the best eligible input, slot 1 the next, and slot 2 the third. Entries are ordered by priority and then by lowest index. A slot with no entry reports none = 1 and index 0.
- R11: With FORCE_REVERT = 1, the block behaves as revertive regardless of revert_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Priority write strobe |
| cfg_idx | input | IDX_W | Input whose priority is written |
| cfg_prio | input | 4 | Priority value written (0 = disabled) |
| revert_mode | input | 1 | 1 = revertive, 0 = nonrevertive |
| ref_valid | input | N_IN | Per-input validity flags |
| sel_idx | output | IDX_W | Selected input index |
| sel_none | output | 1 | No input is selected |
| tab_idx | output | 3*IDX_W | Table indices, slot s at bits s*IDX_W upward |
| tab_none | output | 3 | Per-slot empty flags |

## Verification
A corrupted held selection shows up at the ports exactly one edge after the stimulus that exposes it. Examples are a nonrevertive choice being dropped, or a failover landing on the wrong peer in the circular order. The bench therefore compares sel_idx, sel_none and all three table slots against a cycle-accurate model after every clock. A stale priority register surfaces in the table on the edge after the write. The same stimulus also drives a second instance that is forced to revertive operation, so errors in the revert path appear even when revert_mode is low.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
   localparam int PRIO_W = 4;
   typedef logic [PRIO_W-1:0] prio_t;
   localparam prio_t PRIO_OFF = '0;
endpackage

// File: rtl/refsel_prio_bank.sv
module refsel_prio_bank
   import refsel_pkg::*;
#(
   parameter int N_IN  = 8,
   parameter int IDX_W = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr,
   input  logic [IDX_W-1:0]        idx,
   input  prio_t                   wdata,
   output logic [N_IN*PRIO_W-1:0]  prio_flat
);
   for (genvar g = 0; g < N_IN; g++) begin : g_reg
      prio_t prio_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            prio_q <= PRIO_OFF;
         else if (wr && idx == IDX_W'(g))
            prio_q <= wdata;
      end
      assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q;
   end
endmodule

// File: rtl/refsel_rank_table.sv
module refsel_rank_table
   import refsel_pkg::*;
#(
   parameter int N_IN  = 8,
   parameter int IDX_W = 3,
   parameter int SLOTS = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_IN-1:0]         elig,
   input  logic [N_IN*PRIO_W-1:0]  prio_flat,
   output logic [SLOTS*IDX_W-1:0]  tab_idx,
   output logic [SLOTS-1:0]        tab_none
);
   logic [IDX_W-1:0] nxt_idx [SLOTS];
   logic [SLOTS-1:0] nxt_none;
   logic [IDX_W-1:0] idx_q [SLOTS];
   logic [SLOTS-1:0] none_q;

   if (SLOTS > N_IN) begin : g_bad_slots
      $error("refsel_rank_table: SLOTS must not exceed N_IN");
   end

   always_comb begin
      logic [N_IN-1:0] taken;
      logic            found;
      int              bi;
      prio_t           bp;
      prio_t           p;
      taken = '0;
      for (int s = 0; s < SLOTS; s++) begin
         found = 1'b0;
         bi    = 0;
         bp    = '0;
         for (int i = 0; i < N_IN; i++) begin
            p = prio_flat[i*PRIO_W +: PRIO_W];
            if (elig[i] && !taken[i] && (!found || p < bp)) begin
               found = 1'b1;
               bi    = i;
               bp    = p;
            end
         end
         if (found) taken[bi] = 1'b1;
         nxt_idx[s]  = found ? IDX_W'(bi) : '0;
         nxt_none[s] = !found;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         none_q <= '1;
         for (int s = 0; s < SLOTS; s++) idx_q[s] <= '0;
      end else begin
         none_q <= nxt_none;
         for (int s = 0; s < SLOTS; s++) idx_q[s] <= nxt_idx[s];
      end
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_out
      assign tab_idx[s*IDX_W +: IDX_W] = idx_q[s];
      assign tab_none[s]               = none_q[s];
      AST_EMPTY_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         none_q[s] |-> idx_q[s] == '0); // R10
      if (s > 0) begin : g_pack
         AST_TABLE_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
            !none_q[s] |-> !none_q[s-1]); // R10
         AST_TABLE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            !none_q[s] |-> idx_q[s] != idx_q[s-1]); // R10
      end
   end
endmodule

// File: rtl/refsel_picker.sv
module refsel_picker
   import refsel_pkg::*;
#(
   parameter int N_IN         = 8,
   parameter int IDX_W        = 3,
   parameter bit FORCE_REVERT = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_IN-1:0]         elig,
   input  logic [N_IN*PRIO_W-1:0]  prio_flat,
   input  logic                    revert_mode,
   output logic [IDX_W-1:0]        sel_idx,
   output logic                    sel_none
);
   logic [IDX_W-1:0] sel_q, hit_idx;
   logic             sel_none_q;
   logic [N_IN-1:0]  elig_q;
   logic             revert_eff, any, cur_ok, move;
   prio_t            best_prio, sel_prio;

   assign revert_eff = FORCE_REVERT ? 1'b1 : revert_mode;

   always_comb begin
      int   start;
      int   j;
      logic found;
      any       = 1'b0;
      best_prio = '1;
      for (int i = 0; i < N_IN; i++) begin
         if (elig[i]) begin
            any = 1'b1;
            if (prio_flat[i*PRIO_W +: PRIO_W] < best_prio)
               best_prio = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
      sel_prio = prio_flat[int'(sel_q)*PRIO_W +: PRIO_W];
      cur_ok   = !sel_none_q && elig[sel_q];
      move     = !cur_ok || (revert_eff && sel_prio > best_prio);
      start    = sel_none_q ? N_IN - 1 : int'(sel_q);
      found    = 1'b0;
      hit_idx  = '0;
      for (int k = 1; k <= N_IN; k++) begin
         j = (start + k) % N_IN;
         if (!found && elig[j] && prio_flat[j*PRIO_W +: PRIO_W] == best_prio) begin
            found   = 1'b1;
            hit_idx = IDX_W'(j);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q      <= '0;
         sel_none_q <= 1'b1;
         elig_q     <= '0;
      end else begin
         elig_q <= elig;
         if (!any) begin
            sel_q      <= '0;
            sel_none_q <= 1'b1;
         end else if (move) begin
            sel_q      <= hit_idx;
            sel_none_q <= 1'b0;
         end
      end
   end

   assign sel_idx  = sel_q;
   assign sel_none = sel_none_q;

   AST_EMPTY_GIVES_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (elig == '0) |=> (sel_none_q && sel_q == '0)); // R4
   AST_NEVER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (elig != '0) |=> !sel_none_q); // R6
   AST_SEL_WAS_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_none_q |-> elig_q[sel_q]); // R6
   AST_NONREV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!revert_eff && !sel_none_q && elig[sel_q]) |=> ($stable(sel_q) && !sel_none_q)); // R8
   AST_TIE_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_none_q && elig[sel_q] && sel_prio == best_prio) |=> $stable(sel_q)); // R9
endmodule

// File: rtl/refclk_priority_selector.sv
module refclk_priority_selector
   import refsel_pkg::*;
#(
   parameter int N_IN         = 8,
   parameter bit FORCE_REVERT = 1'b0,
   localparam int IDX_W       = (N_IN > 1) ? $clog2(N_IN) : 1,
   localparam int SLOTS       = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_wr,
   input  logic [IDX_W-1:0]       cfg_idx,
   input  logic [PRIO_W-1:0]      cfg_prio,
   input  logic                   revert_mode,
   input  logic [N_IN-1:0]        ref_valid,
   output logic [IDX_W-1:0]       sel_idx,
   output logic                   sel_none,
   output logic [SLOTS*IDX_W-1:0] tab_idx,
   output logic [SLOTS-1:0]       tab_none
);
   if (N_IN < SLOTS || N_IN > 256) begin : g_bad_n
      $error("refclk_priority_selector: N_IN must lie in 3..256");
   end

   logic [N_IN*PRIO_W-1:0] prio_flat;
   logic [N_IN-1:0]        elig;

   refsel_prio_bank #(.N_IN(N_IN), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .idx(cfg_idx),
      .wdata(cfg_prio), .prio_flat(prio_flat));

   for (genvar g = 0; g < N_IN; g++) begin : g_elig
      assign elig[g] = ref_valid[g] & (prio_flat[g*PRIO_W +: PRIO_W] != PRIO_OFF);
   end

   refsel_picker #(.N_IN(N_IN), .IDX_W(IDX_W), .FORCE_REVERT(FORCE_REVERT)) u_pick (
      .clk(clk), .rst_n(rst_n), .elig(elig), .prio_flat(prio_flat),
      .revert_mode(revert_mode), .sel_idx(sel_idx), .sel_none(sel_none));

   refsel_rank_table #(.N_IN(N_IN), .IDX_W(IDX_W), .SLOTS(SLOTS)) u_rank (
      .clk(clk), .rst_n(rst_n), .elig(elig), .prio_flat(prio_flat),
      .tab_idx(tab_idx), .tab_none(tab_none));

   AST_NONE_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      sel_none |-> sel_idx == '0); // R4
   AST_SEL_IS_TOP_WHEN_REVERT: assert property (@(posedge clk) disable iff (!rst_n)
      (FORCE_REVERT && !sel_none) |-> !tab_none[0]); // R11
endmodule

// File: tb/refclk_priority_selector_tb_top.sv
module refclk_priority_selector_tb_top;
   localparam int N = 8;
   localparam int IW = 3;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0;
   logic [IW-1:0] cfg_idx = '0;
   logic [3:0] cfg_prio = '0;
   logic revert_mode = 1'b0;
   logic [N-1:0] ref_valid = '0;
   logic [IW-1:0] sel_a, sel_b;
   logic none_a, none_b;
   logic [3*IW-1:0] tab_a, tab_b;
   logic [2:0] tnone_a, tnone_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int mprio [N];
   int msel_a, msel_b;
   bit mnone_a, mnone_b;
   int etab [3];
   bit etnone [3];
   bit prev_wr;
   string tag_a, tag_b;

   always #(CLK_PERIOD/2) clk = ~clk;

   refclk_priority_selector #(.N_IN(N), .FORCE_REVERT(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
      .cfg_prio(cfg_prio), .revert_mode(revert_mode), .ref_valid(ref_valid),
      .sel_idx(sel_a), .sel_none(none_a), .tab_idx(tab_a), .tab_none(tnone_a));

   refclk_priority_selector #(.N_IN(N), .FORCE_REVERT(1'b1)) dut_fr_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
      .cfg_prio(cfg_prio), .revert_mode(revert_mode), .ref_valid(ref_valid),
      .sel_idx(sel_b), .sel_none(none_b), .tab_idx(tab_b), .tab_none(tnone_b));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_next(input logic [N-1:0] v, input bit rev, input int cur,
                             input bit cnone, output int nsel, output bit nnone,
                             output string tag);
      int bp;
      bit any;
      bit cur_ok;
      int start;
      bp = 16;
      any = 0;
      for (int i = 0; i < N; i++)
         if (v[i] && mprio[i] != 0) begin
            any = 1;
            if (mprio[i] < bp) bp = mprio[i];
         end
      nsel = cur;
      nnone = cnone;
      if (!any) begin
         nsel = 0; nnone = 1; tag = "R4";
         return;
      end
      cur_ok = !cnone && v[cur] && mprio[cur] != 0;
      if (cnone) tag = "R5";
      else if (!cur_ok) tag = "R6";
      else if (rev && mprio[cur] > bp) tag = "R7";
      else begin
         tag = (mprio[cur] == bp) ? "R9" : "R8";
         return;
      end
      start = cnone ? N - 1 : cur;
      for (int k = 1; k <= N; k++) begin
         int j;
         j = (start + k) % N;
         if (v[j] && mprio[j] == bp) begin
            nsel = j; nnone = 0;
            return;
         end
      end
   endtask

   task automatic model_table(input logic [N-1:0] v);
      bit taken [N];
      for (int i = 0; i < N; i++) taken[i] = 0;
      for (int s = 0; s < 3; s++) begin
         int bi;
         bi = -1;
         for (int i = 0; i < N; i++)
            if (v[i] && mprio[i] != 0 && !taken[i] && (bi < 0 || mprio[i] < mprio[bi]))
               bi = i;
         if (bi >= 0) begin
            taken[bi] = 1; etab[s] = bi; etnone[s] = 0;
         end else begin
            etab[s] = 0; etnone[s] = 1;
         end
      end
   endtask

   task automatic check_all();
      string pa, pb;
      pa = prev_wr ? {"R2/", tag_a} : tag_a;
      pb = {"R11/", tag_b};
      check({pa, " sel_none"}, int'(none_a), int'(mnone_a));
      check({pa, " sel_idx"}, int'(sel_a), msel_a);
      check({pb, " sel_none"}, int'(none_b), int'(mnone_b));
      check({pb, " sel_idx"}, int'(sel_b), msel_b);
      for (int s = 0; s < 3; s++) begin
         check("R10 table slot", int'({tnone_a[s], tab_a[s*IW +: IW]}),
               (int'(etnone[s]) << IW) | etab[s]);
         check("R10 forced table slot", int'({tnone_b[s], tab_b[s*IW +: IW]}),
               (int'(etnone[s]) << IW) | etab[s]);
      end
   endtask

   task automatic run_cycle(input bit wr, input int idx, input int p,
                            input logic [N-1:0] v, input bit rev);
      int na, nb;
      bit nna, nnb;
      cfg_wr = wr; cfg_idx = IW'(idx); cfg_prio = 4'(p);
      ref_valid = v; revert_mode = rev;
      @(posedge clk);
      model_next(v, rev, msel_a, mnone_a, na, nna, tag_a);
      model_next(v, 1'b1, msel_b, mnone_b, nb, nnb, tag_b);
      model_table(v);
      msel_a = na; mnone_a = nna; msel_b = nb; mnone_b = nnb;
      @(negedge clk);
      check_all();
      if (wr) mprio[idx] = p;
      prev_wr = wr;
   endtask

   initial begin
      logic [N-1:0] v;
      bit rev;
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) mprio[i] = 0;
      msel_a = 0; msel_b = 0; mnone_a = 1; mnone_b = 1; prev_wr = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check("R1 sel_none", int'(none_a), 1);
      check("R1 sel_idx", int'(sel_a), 0);
      check("R1 tab_none", int'(tnone_a), 7);
      check("R1 tab_idx", int'(tab_a), 0);
      rst_n = 1'b1;
      // R4: all valid but every priority is zero
      run_cycle(0, 0, 0, '1, 0);
      // R2/R5/R8/R7(forced)/R10: build priorities while all inputs valid
      run_cycle(1, 2, 3, '1, 0);
      run_cycle(1, 5, 3, '1, 0);
      run_cycle(1, 6, 1, '1, 0);
      run_cycle(0, 0, 0, '1, 0);
      run_cycle(0, 0, 0, '1, 0);
      // R6: selected input lost, best remaining takes over
      run_cycle(0, 0, 0, ~(N'(1) << 2), 0);
      run_cycle(1, 6, 3, ~(N'(1) << 2), 0);
      run_cycle(0, 0, 0, (N'(1) << 2) | (N'(1) << 5) | (N'(1) << 6), 0);
      // R6: circular failover among equal priorities
      run_cycle(0, 0, 0, (N'(1) << 2) | (N'(1) << 5), 0);
      run_cycle(0, 0, 0, (N'(1) << 6) | (N'(1) << 5), 0);
      run_cycle(0, 0, 0, (N'(1) << 2) | (N'(1) << 5) | (N'(1) << 6), 1);
      // R3: a change between edges leaves the outputs untouched
      v = ref_valid;
      ref_valid = '0;
      #1;
      check("R3 sel_idx before edge", int'(sel_a), msel_a);
      check("R3 sel_none before edge", int'(none_a), int'(mnone_a));
      run_cycle(0, 0, 0, '0, 1);
      run_cycle(0, 0, 0, v, 1);
      // random phase
      v = '1;
      rev = 0;
      for (int c = 0; c < 4000; c++) begin
         bit wr;
         int idx, p, pick;
         if ($urandom_range(0, 7) == 0) v[$urandom_range(0, N-1)] ^= 1'b1;
         if ($urandom_range(0, 63) == 0) rev = ~rev;
         wr = ($urandom_range(0, 5) == 0);
         idx = $urandom_range(0, N-1);
         pick = $urandom_range(0, 4);
         p = (pick == 4) ? 15 : pick;
         run_cycle(wr, idx, p, v, rev);
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule